// File: doc/BRIEF.md
# Multiplexed Burst Memory Access Sequencer

This block is the device-side command and burst engine of a single-data-rate synchronous memory. The memory has a 32-bit data path, and its lower 22 bits also carry the address. A host presents a start address on the shared bus and pulls the address strobe low at a rising clock edge. The sequencer captures the address together with a read or write command. It then counts a programmable latency and moves eight 32-bit words, one per clock. The words follow a linear order that wraps inside the 8-word aligned block that holds the start address.

On a write, each byte lane can be held back by its own mask bit. On a read, the sequencer drives the bus only while the output enable is low. A registered ready/wait status tells the host when the data phase begins. The storage behind the sequencer is a small behavioural word array. The read latency is a static input, not a programmed register.

Top module: `burst_mux_seq`

## Requirements
- R1: At a rising edge where `ce_n` and `adv_n` are both low, the block captures a start address from the low bits of `bus_in` and starts a new burst.
- R2: The captured command is a write when `we_n` is low at the capture edge and a read otherwise. During a write burst `bus_oe` stays 0.
- R3: A burst moves exactly 8 words. Beat i uses address `(base & ~7) | ((base + i) & 7)`, so the order wraps inside the aligned 8-word block.
- R4: `lat_sel` sets the read latency RL: 0 gives 6, 1 gives 7, and 2 or 3 give 8. Counting the capture edge as edge 0, read beat i is placed on the bus at edge RL-1+i and held for one clock. The host therefore takes the first word at edge RL.
- R5: The write latency is RL-1. Write beat i is taken from `bus_in` at edge RL-1+i after the capture edge. Bus values at other edges are not stored.
- R6: `byte_mask` bit k set to 1 keeps bits 8k+7..8k of the addressed word unchanged during a write beat. Bit k set to 0 stores that byte.
- R7: `wait_n` is 1 out of reset and while idle. It falls at the capture edge. It rises at edge RL-1 for a read and at edge RL-2 for a write.
- R8: `bus_oe` is 1 only while a read word is held and `oe_n` and `ce_n` are both low. With `oe_n` high, a read burst never drives the bus.
- R9: While `adv_n` is high, nothing is captured: `wait_n` stays high, and values on `bus_in` and `we_n` leave the stored words unchanged.
- R10: `ce_n` high forces `bus_oe` to 0 at once. At the next edge the burst is dropped and `wait_n` returns to 1. The burst does not resume when `ce_n` falls again.
- R11: From the capture edge until the first read word, `bus_oe` stays 0, so the shared pins carry no read data while the address phase is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low; captures address and command |
| we_n | input | 1 | Write select, active low, sampled at capture |
| oe_n | input | 1 | Output enable for read data, active low |
| lat_sel | input | 2 | Read latency select (6, 7, 8, 8) |
| byte_mask | input | 4 | Per-byte write mask, 1 = keep stored byte |
| bus_in | input | 32 | Shared pins as seen by the device: address in the low bits, then write data |
| bus_out | output | 32 | Read data for the shared pins, zero when not driven |
| bus_oe | output | 1 | Pin driver enable; 0 means the pins are high-impedance |
| wait_n | output | 1 | Ready status, low while the data phase is not yet ready |

## Verification
The properties check several rules on every cycle. The pins are driven only with `oe_n` low and only once the ready status is high. The ready status can fall only through a capture. A deselect always leaves the block ready and undriven. Each rise of the ready status happens exactly RL-1 or RL-2 edges after the last capture, depending on the command. Other behaviour depends on the stored contents, and only the bench scenarios can show it. This covers the wrap order, the write latch edge against junk placed on the bus outside the window, byte masking, and the fact that an ignored strobe or an aborted burst leaves memory unchanged.

// File: rtl/bmseq_pkg.sv
`timescale 1ns/1ps
package bmseq_pkg;
    localparam int DATA_W    = 32;
    localparam int MUX_W     = 22;
    localparam int BURST_LEN = 8;
    localparam int BEAT_W    = $clog2(BURST_LEN);
    localparam int NBYTES    = DATA_W / 8;
    localparam int CNT_W     = 5;
    localparam int RL_W      = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic              wr_fire;
        logic              rd_fire;
    } beat_ctl_t;

    function automatic logic [RL_W-1:0] rl_of(input logic [1:0] sel);
        case (sel)
            2'd0:    rl_of = 4'd6;
            2'd1:    rl_of = 4'd7;
            default: rl_of = 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/bmseq_ctrl.sv
`timescale 1ns/1ps
module bmseq_ctrl
    import bmseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [1:0]        lat_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output beat_ctl_t         ctl,
    output logic              rd_valid,
    output logic              wait_n
);
    seq_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   edge_n;
    logic [CNT_W-1:0]   first_edge;
    logic [CNT_W-1:0]   last_edge;
    logic [CNT_W-1:0]   ready_edge;
    logic [CNT_W-1:0]   done_edge;
    logic               is_wr_q;
    logic [RL_W-1:0]    rl_q;
    logic               capture;
    logic               active;
    logic               in_window;

    always_comb begin
        capture    = !ce_n && !adv_n;
        active     = (state_q != ST_IDLE) && !ce_n && !capture;
        edge_n     = cnt_q + CNT_W'(1);
        first_edge = CNT_W'(rl_q) - CNT_W'(1);
        last_edge  = first_edge + CNT_W'(BURST_LEN - 1);
        ready_edge = is_wr_q ? first_edge - CNT_W'(1) : first_edge;
        done_edge  = is_wr_q ? last_edge : last_edge + CNT_W'(1);
        in_window  = (edge_n >= first_edge) && (edge_n <= last_edge);
        ctl.beat    = BEAT_W'(edge_n - first_edge);
        ctl.wr_fire = active && is_wr_q && in_window;
        ctl.rd_fire = active && !is_wr_q && in_window;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            is_wr_q  <= 1'b0;
            rl_q     <= rl_of(2'd2);
            base_q   <= '0;
            rd_valid <= 1'b0;
            wait_n   <= 1'b1;
        end else if (ce_n) begin
            state_q  <= ST_IDLE;
            rd_valid <= 1'b0;
            wait_n   <= 1'b1;
        end else if (capture) begin
            state_q  <= ST_LAT;
            cnt_q    <= '0;
            is_wr_q  <= !we_n;
            rl_q     <= rl_of(lat_sel);
            base_q   <= addr_in;
            rd_valid <= 1'b0;
            wait_n   <= 1'b0;
        end else if (state_q != ST_IDLE) begin
            cnt_q    <= edge_n;
            rd_valid <= ctl.rd_fire;
            if (edge_n == ready_edge) wait_n <= 1'b1;
            if (edge_n == first_edge) state_q <= ST_XFER;
            if (edge_n == done_edge)  state_q <= ST_IDLE;
        end else begin
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bmseq_wrap.sv
`timescale 1ns/1ps
module bmseq_wrap
    import bmseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] low_sum;

    always_comb begin
        low_sum = base[BEAT_W-1:0] + beat;
        addr    = {base[ADDR_W-1 -: HI_W], low_sum};
    end
endmodule

// File: rtl/bmseq_store.sv
`timescale 1ns/1ps
module bmseq_store
    import bmseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBYTES-1:0] mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && !mask[b]) lane_mem[addr] <= wdata[8*b +: 8];
            if (rd_en)             lane_q         <= lane_mem[addr];
        end

        assign rdata[8*b +: 8] = lane_q;
    end
endmodule

// File: rtl/burst_mux_seq.sv
`timescale 1ns/1ps
module burst_mux_seq
    import bmseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [1:0]        lat_sel,
    input  logic [NBYTES-1:0] byte_mask,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              wait_n
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] rd_word;
    beat_ctl_t         ctl;
    logic              rd_valid;

    bmseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .we_n     (we_n),
        .lat_sel  (lat_sel),
        .addr_in  (bus_in[ADDR_W-1:0]),
        .base_q   (base_q),
        .ctl      (ctl),
        .rd_valid (rd_valid),
        .wait_n   (wait_n)
    );

    bmseq_wrap #(.ADDR_W(ADDR_W)) u_wrap (
        .base (base_q),
        .beat (ctl.beat),
        .addr (beat_addr)
    );

    bmseq_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .wr_en (ctl.wr_fire),
        .rd_en (ctl.rd_fire),
        .addr  (beat_addr),
        .wdata (bus_in),
        .mask  (byte_mask),
        .rdata (rd_word)
    );

    always_comb begin
        bus_oe  = rd_valid && !oe_n && !ce_n;
        bus_out = bus_oe ? rd_word : '0;
    end
endmodule

// File: rtl/bmseq_checker.sv
`timescale 1ns/1ps
module bmseq_checker
    import bmseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       adv_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [1:0] lat_sel,
    input logic       bus_oe,
    input logic       wait_n
);
    logic [CNT_W-1:0] since_q;
    logic             c_wr;
    logic [RL_W-1:0]  c_rl;
    logic [CNT_W-1:0] exp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '1;
            c_wr    <= 1'b0;
            c_rl    <= rl_of(2'd2);
        end else if (!ce_n && !adv_n) begin
            since_q <= '0;
            c_wr    <= !we_n;
            c_rl    <= rl_of(lat_sel);
        end else if (since_q != '1) begin
            since_q <= since_q + CNT_W'(1);
        end
    end

    assign exp_ready = c_wr ? CNT_W'(c_rl) - CNT_W'(2) : CNT_W'(c_rl) - CNT_W'(1);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !oe_n);

    assert_no_early_drive_R11: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> wait_n);

    assert_capture_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adv_n) |=> !wait_n);

    assert_no_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (adv_n && wait_n) |=> wait_n);

    assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (wait_n && (ce_n ? !bus_oe : 1'b1)));

    assert_ready_edge_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(wait_n) && !$past(ce_n)) |-> (since_q == exp_ready));
endmodule

bind burst_mux_seq bmseq_checker u_bmseq_checker (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .adv_n   (adv_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lat_sel (lat_sel),
    .bus_oe  (bus_oe),
    .wait_n  (wait_n)
);

// File: tb/burst_mux_seq_bench.sv
`timescale 1ns/1ps
module burst_mux_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [1:0]  lat_sel = 2'd0;
    logic [3:0]  byte_mask = 4'h0;
    logic [31:0] bus_in = 32'h0;
    logic [31:0] bus_out;
    logic        bus_oe;
    logic        wait_n;

    always #5 clk = ~clk;

    burst_mux_seq u_burst_mux_seq (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .lat_sel(lat_sel), .byte_mask(byte_mask),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wait_n(wait_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit live = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ref_rl(input int sel);
        return (sel == 0) ? 6 : (sel == 1) ? 7 : 8;
    endfunction

    function automatic int baddr(input int base, input int i);
        return (base & 56) | ((base + i) & 7);
    endfunction

    // behavioural reference model
    logic [31:0] ref_mem [64];
    bit          m_busy = 0, m_wait = 1, m_rdv = 0, m_wr = 0;
    int          m_n = 0, m_base = 0, m_rl = 8;
    logic [31:0] m_data = 0;

    initial for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_wait = 1; m_rdv = 0;
        end else if (ce_n) begin
            m_busy = 0; m_wait = 1; m_rdv = 0;
        end else if (!adv_n) begin
            m_busy = 1; m_n = 0; m_wr = !we_n; m_base = int'(bus_in[5:0]);
            m_rl = ref_rl(int'(lat_sel)); m_wait = 0; m_rdv = 0;
        end else if (m_busy) begin
            m_n++;
            if (m_wr) begin
                if (m_n == m_rl - 2) m_wait = 1;
                if (m_n >= m_rl - 1 && m_n <= m_rl + 6) begin
                    int a;
                    a = baddr(m_base, m_n - (m_rl - 1));
                    for (int b = 0; b < 4; b++)
                        if (!byte_mask[b]) ref_mem[a][8*b +: 8] = bus_in[8*b +: 8];
                end
                if (m_n == m_rl + 6) m_busy = 0;
            end else begin
                if (m_n == m_rl - 1) m_wait = 1;
                if (m_n >= m_rl - 1 && m_n <= m_rl + 6) begin
                    m_rdv = 1;
                    m_data = ref_mem[baddr(m_base, m_n - (m_rl - 1))];
                end else begin
                    m_rdv = 0;
                end
                if (m_n == m_rl + 7) m_busy = 0;
            end
        end else begin
            m_rdv = 0;
        end
    end

    always @(negedge clk) begin
        if (live && !finished) begin
            #1;
            chk(wait_n === m_wait, "R7 per-cycle wait_n", {31'b0, wait_n}, {31'b0, m_wait});
            chk(bus_oe === (m_rdv && !oe_n && !ce_n), "R8 per-cycle bus_oe",
                {31'b0, bus_oe}, {31'b0, (m_rdv && !oe_n && !ce_n)});
            if (bus_oe) chk(bus_out === m_data, "R3 per-cycle data", bus_out, m_data);
        end
    end

    logic [31:0] got[$];

    task automatic cmd(input bit wr, input int base, input int sel);
        lat_sel = 2'(sel);
        adv_n = 1'b0;
        we_n = !wr;
        bus_in = 32'(base);
        @(negedge clk);
        adv_n = 1'b1;
        we_n = 1'b1;
        bus_in = 32'h0;
    endtask

    task automatic write_burst(input int base, input int sel,
                               input logic [31:0] w[8], input logic [3:0] m[8]);
        int rl = ref_rl(sel);
        int first_rdy = -1;
        cmd(1, base, sel);
        for (int k = 1; k <= rl + 7; k++) begin
            int idx = k - (rl - 1);
            if (idx >= 0 && idx < 8) begin
                bus_in = w[idx];
                byte_mask = m[idx];
            end else begin
                bus_in = 32'hDEAD_0000 | 32'(k);
                byte_mask = 4'h0;
            end
            @(negedge clk);
            chk(!bus_oe, "R2 write burst leaves bus undriven", {31'b0, bus_oe}, 32'h0);
            if (wait_n && first_rdy < 0) first_rdy = k;
        end
        chk(first_rdy == rl - 2, "R7 write ready edge", 32'(first_rdy), 32'(rl - 2));
        bus_in = 32'h0;
        byte_mask = 4'h0;
        @(negedge clk);
    endtask

    task automatic read_burst(input int base, input int sel, input bit oe_low, input string tag);
        int rl = ref_rl(sel);
        int first_oe = -1;
        int first_rdy = -1;
        logic [31:0] exp[8];
        for (int i = 0; i < 8; i++) exp[i] = ref_mem[baddr(base, i)];
        got.delete();
        oe_n = !oe_low;
        cmd(0, base, sel);
        for (int k = 1; k <= rl + 9; k++) begin
            @(negedge clk);
            if (bus_oe) begin
                got.push_back(bus_out);
                if (first_oe < 0) first_oe = k;
            end
            if (k < rl - 1) chk(!bus_oe, "R11 no drive before first word", {31'b0, bus_oe}, 32'h0);
            if (wait_n && first_rdy < 0) first_rdy = k;
        end
        oe_n = 1'b0;
        if (oe_low) begin
            chk(got.size() == 8, "R3 beat count", 32'(got.size()), 32'd8);
            chk(first_oe == rl - 1, "R4 first read word edge", 32'(first_oe), 32'(rl - 1));
            chk(first_rdy == rl - 1, "R7 read ready edge", 32'(first_rdy), 32'(rl - 1));
            for (int i = 0; i < 8 && i < got.size(); i++)
                chk(got[i] === exp[i], tag, got[i], exp[i]);
        end else begin
            chk(got.size() == 0, "R8 oe_n high keeps bus undriven", 32'(got.size()), 32'd0);
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] wa[8], wb[8], wc[8];
        logic [3:0]  m0[8], mv[8];
        for (int i = 0; i < 8; i++) begin
            wa[i] = 32'hA000_0000 + 32'(i) * 32'h0101_0101 + 32'(i);
            wb[i] = 32'hB0B0_0000 + 32'(i) * 32'h0011_0203;
            wc[i] = 32'hC3C3_C3C3 ^ (32'(i) << 4);
            m0[i] = 4'h0;
        end
        mv = '{4'h0, 4'hF, 4'h1, 4'h2, 4'h4, 4'h8, 4'h5, 4'hA};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wait_n === 1'b1, "R7 reset wait_n", {31'b0, wait_n}, 32'h1);
        chk(bus_oe === 1'b0, "R8 reset bus_oe", {31'b0, bus_oe}, 32'h0);
        live = 1;
        ce_n = 1'b0;
        @(negedge clk);

        write_burst(16, 0, wa, m0);                 // R5 aligned write, RL 6
        read_burst(16, 0, 1, "R1/R5 readback aligned");
        read_burst(21, 1, 1, "R3 wrap order RL7");  // beats 5,6,7,0..4
        chk(got.size() > 0 && got[0] === wa[5], "R3 wrap first beat", got.size() > 0 ? got[0] : 32'h0, wa[5]);

        write_burst(32, 2, wb, m0);
        write_burst(35, 3, wc, mv);                 // wrapping masked write, RL 8
        read_burst(32, 2, 1, "R6 masked readback");
        chk(got.size() == 8 && got[4] === wb[4], "R6 fully masked word kept",
            got.size() == 8 ? got[4] : 32'h0, wb[4]);
        chk(got.size() == 8 && got[3] === wc[0], "R6 unmasked word stored",
            got.size() == 8 ? got[3] : 32'h0, wc[0]);

        read_burst(16, 0, 0, "R8 oe_n high");

        for (int k = 0; k < 12; k++) begin          // R9 strobe held high
            we_n = 1'b0;
            bus_in = 32'h5555_0010 + 32'(k);
            @(negedge clk);
            chk(wait_n === 1'b1, "R9 no capture wait_n", {31'b0, wait_n}, 32'h1);
            chk(bus_oe === 1'b0, "R9 no capture bus_oe", {31'b0, bus_oe}, 32'h0);
        end
        we_n = 1'b1;
        bus_in = 32'h0;
        read_burst(16, 0, 1, "R9 memory unchanged");
        chk(got.size() > 0 && got[0] === wa[0], "R9 first word unchanged", got.size() > 0 ? got[0] : 32'h0, wa[0]);

        cmd(0, 16, 0);                              // R10 abort mid-read
        repeat (6) @(negedge clk);
        chk(bus_oe === 1'b1, "R10 read active before abort", {31'b0, bus_oe}, 32'h1);
        ce_n = 1'b1;
        #1;
        chk(bus_oe === 1'b0, "R10 bus released at once", {31'b0, bus_oe}, 32'h0);
        @(negedge clk);
        chk(wait_n === 1'b1, "R10 idle after abort", {31'b0, wait_n}, 32'h1);
        ce_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(bus_oe === 1'b0, "R10 burst not resumed", {31'b0, bus_oe}, 32'h0);
        end

        read_burst(32, 3, 1, "R4 lat_sel 3 readback");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule